// File: doc/BRIEF.md
# Flash Access Guard

This block sits between every requester of the on-chip non-volatile memories and the memory controller, and decides for each access request whether it may proceed. A request carries an address, a read or write direction and the access mode of the requester: normal CPU run, in-application programming (IAP), in-circuit programming (ICP) or debug. The guard decodes the address into program memory, data EEPROM, option bytes or unmapped space. It then combines the mode with the write-key unlock flags, a boot-code area size given in 64-byte pages and a read-out protection flag. One cycle after the request it answers with exactly one of grant or deny.

The boot-code area starts at the base of program memory. It stays write-locked during in-application programming even when the program memory keys have been accepted. The read-out protection flag is owned by the guard. A set request arms it while it is off. Once it is armed, any request to change it in either direction produces a one-cycle mass-erase pulse. The flag then stays armed until the memory controller reports that the erase is done, and during that wait every access is refused. Denied writes raise a sticky error flag that software clears by writing 1.

Top module: `flash_guard`

## Requirements
- R1: A request sampled at a clock edge is answered after that edge by exactly one of `acc_grant` / `acc_deny`, held for one cycle; with no request both stay low.
- R2: In run mode (`acc_mode` = 0), reads of program memory, data EEPROM and option bytes are granted whatever the protection flag is, and all writes are denied.
- R3: An address is in the boot-code area when its offset from program memory base (0x8000) is below N×64, where N is `boot_pages` with 0 taken as 1 and values above 128 taken as 128.
- R4: In IAP mode (`acc_mode` = 1), a program memory write is granted only when `pm_unlocked` is high and the address is outside the boot-code area; reads are granted.
- R5: Data EEPROM (0x4000 to 0x407F) writes in IAP, ICP or debug mode are granted only when `ee_unlocked` is high, and in ICP and debug only while protection is off.
- R6: In ICP (`acc_mode` = 2) or debug (`acc_mode` = 3) mode with protection active, every program memory and data EEPROM access is denied. With protection off, reads are granted and program memory writes need only `pm_unlocked`; the boot area is not locked.
- R7: Option-byte reads (0x4800 to 0x483F) are granted in every mode and writes there are denied; accesses to unmapped addresses are denied.
- R8: While protection is off, `rop_set_req` turns it on after the next edge without an erase pulse, and `rop_clr_req` is ignored.
- R9: While protection is on, a set or clear request produces `mass_erase` high for exactly the one cycle after that edge. `rop_active` stays high until `erase_done` is sampled, then drops.
- R10: Between the erase pulse and `erase_done`, every access is denied and further change requests produce no new pulse.
- R11: `wp_err` is set by any denied write and cleared by `wp_err_clr`; when both happen in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request present this cycle |
| acc_addr | input | 16 | Byte address of the access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_mode | input | 2 | 0 run, 1 IAP, 2 ICP, 3 debug |
| boot_pages | input | 8 | Boot-code area size in 64-byte pages |
| pm_unlocked | input | 1 | Program memory write keys accepted |
| ee_unlocked | input | 1 | Data EEPROM write keys accepted |
| rop_set_req | input | 1 | Request to turn read-out protection on |
| rop_clr_req | input | 1 | Request to turn read-out protection off |
| erase_done | input | 1 | Memory controller finished the global erase |
| wp_err_clr | input | 1 | Software write-1-to-clear of the error flag |
| acc_grant | output | 1 | Previous-cycle access allowed |
| acc_deny | output | 1 | Previous-cycle access refused |
| mass_erase | output | 1 | One-cycle global erase trigger |
| rop_active | output | 1 | Read-out protection currently armed |
| wp_err | output | 1 | Sticky write-protection error |

## Verification
Every decision is registered once, so a wrong region decode, a wrong boot boundary or a wrong protection flag shows on `acc_grant`/`acc_deny` in the cycle right after the offending request. The bench therefore probes both sides of each page boundary and each mode. A protection state machine stuck in the erase state would deny every later access, including run-mode reads, and would also keep `rop_active` high. A lost or repeated erase pulse shows on `mass_erase` within one cycle of the change request.

// File: rtl/fg_pkg.sv
package fg_pkg;

  typedef enum logic [1:0] {
    MODE_RUN = 2'd0,
    MODE_IAP = 2'd1,
    MODE_ICP = 2'd2,
    MODE_DBG = 2'd3
  } acc_mode_e;

  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_PROG = 2'd1,
    RGN_EE   = 2'd2,
    RGN_OPT  = 2'd3
  } region_e;

  typedef enum logic [1:0] {
    ROP_OFF   = 2'd0,
    ROP_ON    = 2'd1,
    ROP_ERASE = 2'd2
  } rop_state_e;

  typedef struct packed {
    region_e rgn;
    logic    boot_hit;
  } decode_t;

  // Requested page count forced into 1..max_pages.
  function automatic int unsigned clamp_pages(input int unsigned req,
                                              input int unsigned max_pages);
    if (req == 0) return 1;
    if (req > max_pages) return max_pages;
    return req;
  endfunction

  // Offset from program base lies inside the boot-code area.
  function automatic logic in_boot(input int unsigned offset,
                                   input int unsigned pages,
                                   input int unsigned page_bytes);
    return offset < pages * page_bytes;
  endfunction

  // Byte window test: base <= addr < base + size.
  function automatic logic in_window(input int unsigned addr,
                                     input int unsigned base,
                                     input int unsigned size);
    return (addr >= base) && (addr < base + size);
  endfunction

endpackage

// File: rtl/fg_region_dec.sv
module fg_region_dec
  import fg_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned PAGE_W     = 8,
  parameter int unsigned PAGE_BYTES = 64,
  parameter int unsigned PROG_PAGES = 128,
  parameter int unsigned PROG_BASE  = 32'h8000,
  parameter int unsigned EE_BASE    = 32'h4000,
  parameter int unsigned EE_BYTES   = 128,
  parameter int unsigned OPT_BASE   = 32'h4800,
  parameter int unsigned OPT_BYTES  = 64
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [PAGE_W-1:0] boot_pages,
  output decode_t           dec
);
  localparam int unsigned PROG_BYTES = PROG_PAGES * PAGE_BYTES;

  logic [31:0] a32;
  logic        prog_hit, ee_hit, opt_hit;
  int unsigned eff_pages;

  assign a32       = 32'(addr);
  assign prog_hit  = in_window(a32, PROG_BASE, PROG_BYTES);
  assign ee_hit    = in_window(a32, EE_BASE, EE_BYTES);
  assign opt_hit   = in_window(a32, OPT_BASE, OPT_BYTES);
  assign eff_pages = clamp_pages(32'(boot_pages), PROG_PAGES);

  always_comb begin
    dec.rgn      = RGN_NONE;
    dec.boot_hit = 1'b0;
    if (prog_hit) begin
      dec.rgn      = RGN_PROG;
      dec.boot_hit = in_boot(a32 - PROG_BASE, eff_pages, PAGE_BYTES);
    end else if (ee_hit) begin
      dec.rgn = RGN_EE;
    end else if (opt_hit) begin
      dec.rgn = RGN_OPT;
    end
  end

  // R3: boot area never extends past program memory, and only program hits flag it
  always_comb begin
    a_r3_boot_inside_prog: assert (!dec.boot_hit || dec.rgn == RGN_PROG)
      else $error("boot hit outside program memory");
  end

endmodule

// File: rtl/fg_rop_ctrl.sv
module fg_rop_ctrl
  import fg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  input  logic erase_done,
  output logic rop_active,
  output logic erasing,
  output logic mass_erase
);
  rop_state_e state;
  logic       change_req;

  assign change_req = set_req || clr_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ROP_OFF;
      mass_erase <= 1'b0;
    end else begin
      mass_erase <= 1'b0;
      unique case (state)
        ROP_OFF:   if (set_req) state <= ROP_ON;
        ROP_ON: begin
          if (change_req) begin
            state      <= ROP_ERASE;
            mass_erase <= 1'b1;
          end
        end
        ROP_ERASE: if (erase_done) state <= ROP_OFF;
        default:   state <= ROP_OFF;
      endcase
    end
  end

  assign rop_active = (state != ROP_OFF);
  assign erasing    = (state == ROP_ERASE);

  // R9: erase trigger lasts a single cycle
  a_r9_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    mass_erase |=> !mass_erase);

  // R9: flag drops only after the erase-done report
  a_r9_clear_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rop_active) |-> $past(erase_done));

  // R8: arming never comes with an erase
  a_r8_arm_without_erase: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rop_active) |-> !mass_erase);

  // R10: no second pulse while an erase is pending
  a_r10_no_repulse: assert property (@(posedge clk) disable iff (!rst_n)
    erasing && mass_erase |=> !mass_erase);

  // R9: a pulse always leaves the block in the erase wait
  a_r9_pulse_enters_wait: assert property (@(posedge clk) disable iff (!rst_n)
    mass_erase |-> erasing && rop_active);

endmodule

// File: rtl/fg_policy.sv
module fg_policy
  import fg_pkg::*;
(
  input  acc_mode_e mode,
  input  logic      write,
  input  decode_t   dec,
  input  logic      pm_unlocked,
  input  logic      ee_unlocked,
  input  logic      rop_active,
  input  logic      erasing,
  output logic      allow
);
  logic key_ok;

  assign key_ok = (dec.rgn == RGN_PROG) ? pm_unlocked : ee_unlocked;

  always_comb begin
    allow = 1'b0;
    if (!erasing) begin
      unique case (dec.rgn)
        RGN_NONE: allow = 1'b0;
        RGN_OPT:  allow = !write;
        default: begin
          unique case (mode)
            MODE_RUN: allow = !write;
            MODE_IAP: begin
              if (!write)                    allow = 1'b1;
              else if (dec.rgn == RGN_PROG)  allow = pm_unlocked && !dec.boot_hit;
              else                           allow = ee_unlocked;
            end
            default: begin
              if (rop_active)  allow = 1'b0;
              else if (!write) allow = 1'b1;
              else             allow = key_ok;
            end
          endcase
        end
      endcase
    end
  end

  // R10: nothing passes during an erase wait
  always_comb begin
    a_r10_erase_blocks_all: assert (!(erasing && allow))
      else $error("access allowed during erase");
  end

endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import fg_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned PAGE_W     = 8,
  parameter int unsigned PAGE_BYTES = 64,
  parameter int unsigned PROG_PAGES = 128,
  parameter int unsigned PROG_BASE  = 32'h8000,
  parameter int unsigned EE_BASE    = 32'h4000,
  parameter int unsigned EE_BYTES   = 128,
  parameter int unsigned OPT_BASE   = 32'h4800,
  parameter int unsigned OPT_BYTES  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic [1:0]        acc_mode,
  input  logic [PAGE_W-1:0] boot_pages,
  input  logic              pm_unlocked,
  input  logic              ee_unlocked,
  input  logic              rop_set_req,
  input  logic              rop_clr_req,
  input  logic              erase_done,
  input  logic              wp_err_clr,
  output logic              acc_grant,
  output logic              acc_deny,
  output logic              mass_erase,
  output logic              rop_active,
  output logic              wp_err
);
  decode_t   dec;
  acc_mode_e mode;
  logic      allow;
  logic      erasing;
  logic      wp_set;

  assign mode = acc_mode_e'(acc_mode);

  fg_region_dec #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PAGE_BYTES(PAGE_BYTES),
    .PROG_PAGES(PROG_PAGES), .PROG_BASE(PROG_BASE),
    .EE_BASE(EE_BASE), .EE_BYTES(EE_BYTES),
    .OPT_BASE(OPT_BASE), .OPT_BYTES(OPT_BYTES)
  ) u_dec (
    .addr(acc_addr), .boot_pages(boot_pages), .dec(dec)
  );

  fg_rop_ctrl u_rop (
    .clk(clk), .rst_n(rst_n),
    .set_req(rop_set_req), .clr_req(rop_clr_req), .erase_done(erase_done),
    .rop_active(rop_active), .erasing(erasing), .mass_erase(mass_erase)
  );

  fg_policy u_pol (
    .mode(mode), .write(acc_write), .dec(dec),
    .pm_unlocked(pm_unlocked), .ee_unlocked(ee_unlocked),
    .rop_active(rop_active), .erasing(erasing), .allow(allow)
  );

  assign wp_set = acc_valid && acc_write && !allow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_grant <= 1'b0;
      acc_deny  <= 1'b0;
      wp_err    <= 1'b0;
    end else begin
      acc_grant <= acc_valid && allow;
      acc_deny  <= acc_valid && !allow;
      if (wp_set)          wp_err <= 1'b1;
      else if (wp_err_clr) wp_err <= 1'b0;
    end
  end

  // R1: one answer per request, none without
  a_r1_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> (acc_grant != acc_deny));
  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !acc_grant && !acc_deny);

  // R4: boot-area writes in IAP are refused even with keys accepted
  a_r4_boot_locked: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_write && acc_mode == 2'd1 && dec.boot_hit |=> acc_deny);

  // R6: protection shuts out programming and debug access to both memories
  a_r6_rop_lockout: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && rop_active && acc_mode[1] &&
    (dec.rgn == RGN_PROG || dec.rgn == RGN_EE) |=> acc_deny);

  // R2: run-mode reads of mapped memory pass when no erase is pending
  a_r2_run_read: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_write && acc_mode == 2'd0 && !erasing &&
    dec.rgn != RGN_NONE |=> acc_grant);

  // R11: denied write sets the flag; it holds until cleared
  a_r11_set_on_deny: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_write && !allow |=> wp_err);
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    wp_err && !wp_err_clr |=> wp_err);

endmodule

// File: tb/sim_flash_guard.sv
module sim_flash_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [15:0] acc_addr = '0;
  logic        acc_write = 1'b0;
  logic [1:0]  acc_mode = 2'd0;
  logic [7:0]  boot_pages = 8'd4;
  logic        pm_unlocked = 1'b0;
  logic        ee_unlocked = 1'b0;
  logic        rop_set_req = 1'b0;
  logic        rop_clr_req = 1'b0;
  logic        erase_done = 1'b0;
  logic        wp_err_clr = 1'b0;
  logic        acc_grant, acc_deny, mass_erase, rop_active, wp_err;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  flash_guard u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_write(acc_write), .acc_mode(acc_mode), .boot_pages(boot_pages),
    .pm_unlocked(pm_unlocked), .ee_unlocked(ee_unlocked),
    .rop_set_req(rop_set_req), .rop_clr_req(rop_clr_req),
    .erase_done(erase_done), .wp_err_clr(wp_err_clr),
    .acc_grant(acc_grant), .acc_deny(acc_deny), .mass_erase(mass_erase),
    .rop_active(rop_active), .wp_err(wp_err)
  );

  localparam logic [1:0] RUN = 2'd0, IAP = 2'd1, ICP = 2'd2, DBG = 2'd3;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One request; answer sampled at the following falling edge.
  task automatic acc(input logic [1:0] m, input logic [15:0] a, input bit w,
                     input bit exp_g, input string req);
    int act;
    @(negedge clk);
    acc_valid = 1'b1; acc_mode = m; acc_addr = a; acc_write = w;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
    act = {acc_grant, acc_deny};
    chk(acc_grant == exp_g && acc_deny == !exp_g, req,
        $sformatf("grant/deny mode %0d addr %h wr %0d", m, a, w),
        act, exp_g ? 2 : 1);
  endtask

  task automatic t_reset;
    chk(!acc_grant && !acc_deny && !mass_erase && !rop_active && !wp_err,
        "R1", "reset outputs", {acc_grant, acc_deny, mass_erase, rop_active, wp_err}, 0);
  endtask

  task automatic t_idle;
    @(negedge clk); @(negedge clk);
    chk(!acc_grant && !acc_deny, "R1", "idle answer", {acc_grant, acc_deny}, 0);
  endtask

  task automatic t_run;
    acc(RUN, 16'h8000, 0, 1, "R2");
    acc(RUN, 16'h4010, 0, 1, "R2");
    acc(RUN, 16'h4805, 0, 1, "R2");
    pm_unlocked = 1'b1;
    acc(RUN, 16'h9000, 1, 0, "R2");
    pm_unlocked = 1'b0;
  endtask

  task automatic t_boot_size;
    pm_unlocked = 1'b1;
    boot_pages = 8'd4;
    acc(IAP, 16'h80FF, 1, 0, "R3");
    acc(IAP, 16'h8100, 1, 1, "R3");
    boot_pages = 8'd0;
    acc(IAP, 16'h803F, 1, 0, "R3");
    acc(IAP, 16'h8040, 1, 1, "R3");
    boot_pages = 8'd200;
    acc(IAP, 16'h9FFF, 1, 0, "R3");
    boot_pages = 8'd127;
    acc(IAP, 16'h9FC0, 1, 1, "R3");
    boot_pages = 8'd128;
    acc(IAP, 16'h9FC0, 1, 0, "R3");
    boot_pages = 8'd1;
    pm_unlocked = 1'b0;
  endtask

  task automatic t_iap;
    pm_unlocked = 1'b0;
    acc(IAP, 16'h9000, 1, 0, "R4");
    acc(IAP, 16'h8000, 0, 1, "R4");
    pm_unlocked = 1'b1;
    acc(IAP, 16'h9000, 1, 1, "R4");
    acc(IAP, 16'h8010, 1, 0, "R4");
    pm_unlocked = 1'b0;
  endtask

  task automatic t_ee;
    ee_unlocked = 1'b0;
    acc(IAP, 16'h407F, 1, 0, "R5");
    acc(DBG, 16'h4000, 1, 0, "R5");
    ee_unlocked = 1'b1;
    acc(IAP, 16'h407F, 1, 1, "R5");
    acc(ICP, 16'h4000, 1, 1, "R5");
    acc(IAP, 16'h4080, 0, 0, "R7");
    ee_unlocked = 1'b0;
  endtask

  task automatic t_icp_open;
    acc(ICP, 16'h9ABC, 0, 1, "R6");
    acc(DBG, 16'h4020, 0, 1, "R6");
    acc(ICP, 16'h8000, 1, 0, "R6");
    pm_unlocked = 1'b1;
    acc(ICP, 16'h8000, 1, 1, "R6");
    pm_unlocked = 1'b0;
  endtask

  task automatic t_opt;
    acc(DBG, 16'h4800, 0, 1, "R7");
    acc(ICP, 16'h483F, 0, 1, "R7");
    acc(IAP, 16'h4800, 1, 0, "R7");
    acc(RUN, 16'h0000, 0, 0, "R7");
    acc(DBG, 16'h4840, 0, 0, "R7");
  endtask

  task automatic t_wp;
    @(negedge clk); wp_err_clr = 1'b1;
    @(negedge clk); wp_err_clr = 1'b0;
    chk(wp_err == 1'b0, "R11", "cleared", wp_err, 0);
    acc(RUN, 16'h8000, 0, 1, "R11");
    chk(wp_err == 1'b0, "R11", "granted read leaves flag", wp_err, 0);
    acc(RUN, 16'h4000, 1, 0, "R11");
    chk(wp_err == 1'b1, "R11", "set by denied write", wp_err, 1);
    @(negedge clk);
    chk(wp_err == 1'b1, "R11", "holds", wp_err, 1);
    @(negedge clk); wp_err_clr = 1'b1;
    @(negedge clk); wp_err_clr = 1'b0;
    chk(wp_err == 1'b0, "R11", "clear", wp_err, 0);
    @(negedge clk);
    acc_valid = 1'b1; acc_mode = IAP; acc_addr = 16'h8000; acc_write = 1'b1;
    wp_err_clr = 1'b1;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0; wp_err_clr = 1'b0;
    chk(wp_err == 1'b1, "R11", "set wins over clear", wp_err, 1);
  endtask

  task automatic t_rop_arm;
    @(negedge clk); rop_clr_req = 1'b1;
    @(negedge clk); rop_clr_req = 1'b0;
    chk(!rop_active && !mass_erase, "R8", "clear while off ignored",
        {rop_active, mass_erase}, 0);
    @(negedge clk); rop_set_req = 1'b1;
    @(negedge clk); rop_set_req = 1'b0;
    chk(rop_active && !mass_erase, "R8", "arm without erase",
        {rop_active, mass_erase}, 2);
  endtask

  task automatic t_rop_locked;
    acc(ICP, 16'h9000, 0, 0, "R6");
    acc(DBG, 16'h4000, 0, 0, "R6");
    ee_unlocked = 1'b1;
    acc(DBG, 16'h4001, 1, 0, "R6");
    ee_unlocked = 1'b0;
    acc(RUN, 16'h8000, 0, 1, "R2");
    acc(IAP, 16'h4010, 0, 1, "R2");
    acc(ICP, 16'h4800, 0, 1, "R7");
  endtask

  task automatic t_rop_toggle;
    @(negedge clk); rop_clr_req = 1'b1;
    @(negedge clk); rop_clr_req = 1'b0;
    chk(mass_erase && rop_active, "R9", "erase pulse, flag held",
        {mass_erase, rop_active}, 3);
    @(negedge clk);
    chk(!mass_erase && rop_active, "R9", "pulse one cycle",
        {mass_erase, rop_active}, 1);
    acc(RUN, 16'h8000, 0, 0, "R10");
    acc(IAP, 16'h4800, 0, 0, "R10");
    @(negedge clk); rop_set_req = 1'b1;
    @(negedge clk); rop_set_req = 1'b0;
    chk(!mass_erase && rop_active, "R10", "no second pulse",
        {mass_erase, rop_active}, 1);
    @(negedge clk); erase_done = 1'b1;
    @(negedge clk); erase_done = 1'b0;
    chk(!rop_active && !mass_erase, "R9", "flag drops after done",
        {rop_active, mass_erase}, 0);
    acc(ICP, 16'h9000, 0, 1, "R6");
  endtask

  task automatic t_set_while_on;
    @(negedge clk); rop_set_req = 1'b1;
    @(negedge clk); rop_set_req = 1'b0;
    chk(rop_active && !mass_erase, "R8", "re-armed", {rop_active, mass_erase}, 2);
    @(negedge clk); rop_set_req = 1'b1;
    @(negedge clk); rop_set_req = 1'b0;
    chk(mass_erase == 1'b1, "R9", "set while on erases", mass_erase, 1);
    @(negedge clk); erase_done = 1'b1;
    @(negedge clk); erase_done = 1'b0;
    chk(!rop_active, "R9", "off after done", rop_active, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_idle;
    t_run;
    t_boot_size;
    t_iap;
    t_ee;
    t_icp_open;
    t_opt;
    t_wp;
    t_rop_arm;
    t_rop_locked;
    t_rop_toggle;
    t_set_while_on;
    t_idle;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule